// File: doc/BRIEF.md
# Single-Channel Quadword Stream DMA

This block is one DMA channel that moves a run of 128-bit quadwords out of memory and onto a streaming output. Software programs it through a narrow write port. It writes a source byte address and a length in quadwords. It then writes the control word with its launch bit set.

Once launched, the engine works one quadword at a time. It issues a single 128-bit read to the memory port and waits for the read-valid return. It then holds the quadword on a valid/ready stream until downstream accepts it, and advances the address by 16 bytes for the next read. The final beat carries a last marker. After that beat is accepted, the engine emits one single-cycle completion indication on two outputs, an interrupt and an event, and drops its running status.

A run status output mirrors the launch bit. It is high while a transfer is in flight and reads back cleared once the transfer has finished. The block is intended to feed a width converter or a bridge that lands the stream in another memory.

Top module: `qdma_channel`

## Requirements
- R1: A register write at offset 0x10 loads the source byte address, and the first memory read of the next transfer uses exactly that address.
- R2: A register write at offset 0x20 loads the length in quadwords. A transfer of length N issues exactly N memory reads and delivers exactly N accepted stream beats, and a length written while busy applies to the next launch.
- R3: A register write at offset 0x00 launches a transfer only when bit 0 of the written data is 1. With bit 0 clear, nothing starts.
- R4: Within one transfer, each memory read address is the previous one plus 16, wrapping modulo 2^32.
- R5: Each stream beat carries the quadword returned by the corresponding read, in order. Data and last hold steady while valid is high and ready is low.
- R6: The last marker is high on the final beat of a transfer and low on every other beat. The completion pulse follows one cycle after the final beat is accepted.
- R7: Each launched transfer produces exactly one completion, a one-cycle pulse that appears on both the interrupt and the event output together. The run status is high during that pulse and low from the next cycle on.
- R8: At most one memory read is outstanding. No new read is issued while a stream beat is waiting for acceptance.
- R9: A launch with length 0 completes with one completion pulse, no memory reads and no stream beats.
- R10: A launch write while a transfer is running is ignored. The running transfer is not disturbed, and no extra transfer or completion follows.
- R11: Synchronous reset clears the address and length registers, drops the run status, and deasserts stream valid and memory read enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_off | input | 8 | Register byte offset (0x00 control, 0x10 address, 0x20 length) |
| reg_wdata | input | 32 | Register write data |
| ctrl_run | output | 1 | Launch-bit readback: high while a transfer runs |
| mem_rd_en | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Byte address of the requested quadword |
| mem_rd_data | input | 128 | Returned quadword |
| mem_rd_valid | input | 1 | Return strobe for mem_rd_data |
| st_valid | output | 1 | Stream beat valid |
| st_data | output | 128 | Stream beat quadword |
| st_last | output | 1 | Final beat of the transfer |
| st_ready | input | 1 | Downstream accepts the beat |
| irq_done | output | 1 | Completion interrupt pulse |
| evt_done | output | 1 | Completion event pulse |

## Verification
The bound checker watches several rules on every cycle. It checks that beats hold steady under backpressure and that only one read is in flight. It checks the 16-byte address stride within a transfer, and that the pulse follows only a beat marked last. It also checks that the completion pulse is one cycle long and is followed by the run status falling, and that the engine stays quiet while not running. Some behaviour can only be shown by the bench's scenarios. These include that the data matches what memory returned, that the counts of reads and beats equal the programmed length, and that a zero length completes empty. They also include that a launch during a transfer is ignored, that a control write without bit 0 does nothing, and that reset really clears the address and length registers. The bench sweeps lengths 0 to 6 across three backpressure patterns and three base addresses, one of them wrapping past the top of the address space.

// File: rtl/qdma_pkg.sv
package qdma_pkg;
  localparam int OFF_W = 8;
  localparam logic [OFF_W-1:0] OFF_CTRL = 8'h00;
  localparam logic [OFF_W-1:0] OFF_SRC  = 8'h10;
  localparam logic [OFF_W-1:0] OFF_LEN  = 8'h20;
  localparam int CTRL_GO_BIT = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } eng_state_e;
endpackage

// File: rtl/qdma_regs.sv
module qdma_regs
  import qdma_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [CNT_W-1:0]  qcount,
  output logic              launch,
  output logic              run_q
);
  logic unused_wbits;
  assign unused_wbits = ^reg_wdata;

  // a launch is accepted only from idle
  assign launch = reg_we && (reg_off == OFF_CTRL) && reg_wdata[CTRL_GO_BIT] && !run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr <= '0;
      qcount   <= '0;
      run_q    <= 1'b0;
    end else begin
      if (reg_we && reg_off == OFF_SRC) src_addr <= reg_wdata[ADDR_W-1:0];
      if (reg_we && reg_off == OFF_LEN) qcount   <= reg_wdata[CNT_W-1:0];
      if (launch)         run_q <= 1'b1;
      else if (xfer_done) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/qdma_engine.sv
module qdma_engine
  import qdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [CNT_W-1:0]  qcount,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_valid,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic              st_last,
  input  logic              st_ready,
  output logic              done_q
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  eng_state_e       state;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      remain      <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      st_valid    <= 1'b0;
      st_data     <= '0;
      st_last     <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      done_q    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            if (qcount == '0) begin
              done_q <= 1'b1;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= src_addr;
              remain      <= qcount;
              state       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rd_valid) begin
            st_valid <= 1'b1;
            st_data  <= mem_rd_data;
            st_last  <= (remain == ONE);
            state    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (st_ready) begin
            st_valid <= 1'b0;
            st_last  <= 1'b0;
            if (remain == ONE) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              remain      <= remain - ONE;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= mem_rd_addr + STEP;
              state       <= ST_WAIT;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qdma_channel.sv
module qdma_channel
  import qdma_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic              ctrl_run,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_valid,
  output logic              st_valid,
  output logic [DATA_W-1:0] st_data,
  output logic              st_last,
  input  logic              st_ready,
  output logic              irq_done,
  output logic              evt_done
);
  logic [ADDR_W-1:0] src_addr;
  logic [CNT_W-1:0]  qcount;
  logic              launch;
  logic              done_q;

  qdma_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .xfer_done(done_q), .src_addr(src_addr), .qcount(qcount),
    .launch(launch), .run_q(ctrl_run)
  );

  qdma_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst(rst), .launch(launch), .src_addr(src_addr), .qcount(qcount),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready),
    .done_q(done_q)
  );

  assign irq_done = done_q;
  assign evt_done = done_q;
endmodule

// File: rtl/qdma_channel_chk.sv
module qdma_channel_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              ctrl_run,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_valid,
  input logic              st_valid,
  input logic [DATA_W-1:0] st_data,
  input logic              st_last,
  input logic              st_ready,
  input logic              irq_done
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  logic              pend;
  logic              seen;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      seen      <= 1'b0;
      prev_addr <= '0;
    end else begin
      if (mem_rd_en)         pend <= 1'b1;
      else if (mem_rd_valid) pend <= 1'b0;
      if (!ctrl_run)      seen <= 1'b0;
      else if (mem_rd_en) seen <= 1'b1;
      if (mem_rd_en) prev_addr <= mem_rd_addr;
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    st_valid && !st_ready |=> st_valid && $stable(st_data) && $stable(st_last));

  assert_one_read_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !pend);

  assert_no_read_during_beat_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !st_valid);

  assert_stride_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en && seen |-> mem_rd_addr == prev_addr + STEP);

  assert_last_then_done_R6: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_ready && st_last |=> irq_done);

  assert_mid_no_done_R6: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_ready && !st_last |=> !irq_done);

  assert_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    irq_done |=> !irq_done && !ctrl_run);

  assert_done_while_run_R7: assert property (@(posedge clk) disable iff (rst)
    irq_done |-> ctrl_run);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !ctrl_run |-> !st_valid && !mem_rd_en);
endmodule

bind qdma_channel qdma_channel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .ctrl_run(ctrl_run), .mem_rd_en(mem_rd_en),
  .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .st_valid(st_valid),
  .st_data(st_data), .st_last(st_last), .st_ready(st_ready), .irq_done(irq_done)
);

// File: tb/qdma_channel_bench.sv
`timescale 1ns/1ps
module qdma_channel_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [7:0]   reg_off = '0;
  logic [31:0]  reg_wdata = '0;
  logic         ctrl_run;
  logic         mem_rd_en;
  logic [31:0]  mem_rd_addr;
  logic [127:0] mem_rd_data = '0;
  logic         mem_rd_valid = 1'b0;
  logic         st_valid;
  logic [127:0] st_data;
  logic         st_last;
  logic         st_ready = 1'b0;
  logic         irq_done;
  logic         evt_done;

  always #2 clk = ~clk;

  qdma_channel u_qdma_channel (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .ctrl_run(ctrl_run), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last), .st_ready(st_ready),
    .irq_done(irq_done), .evt_done(evt_done)
  );

  int checks = 0;
  int errors = 0;
  int rmode = 0;
  logic [31:0] exp_src = '0;
  int exp_n = 0;
  int beat_idx = 0;
  int rd_idx = 0;
  int dones = 0;

  function automatic logic [127:0] pat(input logic [31:0] a);
    return {~a, a ^ 32'h5A5A_5A5A, a + 32'h0000_0011, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: one return per request, latency 0..2 extra cycles
  initial begin
    bit pend = 0;
    int cnt = 0;
    logic [31:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      if (rst) begin
        pend = 0;
      end else begin
        if (pend) begin
          if (cnt == 0) begin
            mem_rd_valid = 1'b1;
            mem_rd_data = pat(paddr);
            pend = 0;
          end else cnt--;
        end
        if (mem_rd_en) begin
          chk(!pend, "R8 read while one outstanding", 128'(pend), 128'(0));
          chk(mem_rd_addr == exp_src + 32'(rd_idx) * 32'd16,
              rd_idx == 0 ? "R1 first read address" : "R4 read address stride",
              128'(mem_rd_addr), 128'(exp_src + 32'(rd_idx) * 32'd16));
          pend = 1;
          paddr = mem_rd_addr;
          cnt = int'(mem_rd_addr[4]) + int'(mem_rd_addr[5]);
          rd_idx++;
        end
      end
    end
  end

  // ready pattern, beat monitor, completion monitor
  initial begin
    int cyc = 0;
    logic [7:0] lfsr = 8'hA7;
    forever begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      case (rmode)
        0: st_ready = 1'b1;
        1: st_ready = cyc[0];
        default: st_ready = lfsr[0] & lfsr[2];
      endcase
      if (!rst) begin
        if (irq_done) dones++;
        if (irq_done != evt_done)
          chk(0, "R7 interrupt and event differ", 128'(irq_done), 128'(evt_done));
        if (st_valid && st_ready) begin
          chk(st_data == pat(exp_src + 32'(beat_idx) * 32'd16), "R5 beat data",
              st_data, pat(exp_src + 32'(beat_idx) * 32'd16));
          chk(st_last == (beat_idx == exp_n - 1), "R6 last marker",
              128'(st_last), 128'(beat_idx == exp_n - 1));
          beat_idx++;
        end
      end
    end
  end

  task automatic reg_write(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_off = '0; reg_wdata = '0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (ctrl_run && g < 3000) begin
      @(negedge clk);
      g++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] src, input int n);
    exp_src = src; exp_n = n; beat_idx = 0; rd_idx = 0; dones = 0;
  endtask

  task automatic end_checks(input int n, input string tag);
    chk(rd_idx == n, {tag, " read count"}, 128'(rd_idx), 128'(n));
    chk(beat_idx == n, {tag, " beat count"}, 128'(beat_idx), 128'(n));
    chk(dones == 1, "R7 one completion", 128'(dones), 128'(1));
    chk(!ctrl_run, "R7 run status cleared", 128'(ctrl_run), 128'(0));
  endtask

  initial begin
    logic [31:0] bases [3];
    bases[0] = 32'h0000_0000;
    bases[1] = 32'h0000_1230;
    bases[2] = 32'hFFFF_FFC0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!st_valid && !mem_rd_en && !ctrl_run && !irq_done, "R11 reset state",
        128'({st_valid, mem_rd_en, ctrl_run, irq_done}), 128'(0));

    // R3: control write without bit 0 does not launch
    arm(32'h0, 0);
    reg_write(8'h20, 32'd3);
    reg_write(8'h00, 32'h0000_0002);
    repeat (10) @(negedge clk);
    chk(!ctrl_run && rd_idx == 0 && dones == 0, "R3 no launch without bit 0",
        128'({ctrl_run, 8'(rd_idx), 8'(dones)}), 128'(0));

    // sweep length x backpressure x base (R1 R2 R4 R5 R6 R7 R9)
    for (int b = 0; b < 3; b++) begin
      for (int m = 0; m < 3; m++) begin
        for (int n = 0; n <= 6; n++) begin
          rmode = m;
          arm(bases[b], n);
          reg_write(8'h10, bases[b]);
          reg_write(8'h20, 32'(n));
          reg_write(8'h00, 32'h1);
          wait_idle();
          end_checks(n, n == 0 ? "R9 zero length" : "R2");
        end
      end
    end

    // R10: launch during a transfer is ignored; length written meanwhile applies next
    rmode = 1;
    arm(32'h0000_2000, 5);
    reg_write(8'h10, 32'h0000_2000);
    reg_write(8'h20, 32'd5);
    reg_write(8'h00, 32'h1);
    repeat (4) @(negedge clk);
    reg_write(8'h20, 32'd2);
    reg_write(8'h00, 32'h1);
    wait_idle();
    end_checks(5, "R10 busy launch ignored");
    repeat (10) @(negedge clk);
    chk(dones == 1 && !ctrl_run, "R10 no extra transfer", 128'(dones), 128'(1));
    arm(32'h0000_2000, 2);
    reg_write(8'h00, 32'h1);
    wait_idle();
    end_checks(2, "R2 length loaded while busy");

    // R11: reset mid-transfer clears state and registers
    rmode = 2;
    arm(32'h0000_3000, 4);
    reg_write(8'h10, 32'h0000_3000);
    reg_write(8'h20, 32'd4);
    reg_write(8'h00, 32'h1);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!st_valid && !mem_rd_en && !ctrl_run, "R11 outputs after reset",
        128'({st_valid, mem_rd_en, ctrl_run}), 128'(0));
    arm(32'h0, 0);
    reg_write(8'h00, 32'h1);
    wait_idle();
    end_checks(0, "R11 length cleared");
    arm(32'h0, 1);
    reg_write(8'h20, 32'd1);
    reg_write(8'h00, 32'h1);
    wait_idle();
    end_checks(1, "R11 address cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule